// File: doc/BRIEF.md
# Shared-Enable Stall Pipeline

A fixed-latency arithmetic pipeline of `DEPTH` stages wrapped in a single valid/stall handshake. Each stage holds a data word and a valid flag and applies a small multiply-add step to its input. One enable signal drives every stage register at once. When the consumer raises its stall, the whole pipeline freezes in the same cycle, and the producer sees a stall in that same cycle. No stage has its own handshake, and nothing buffers the output.

Until the first valid word has been accepted, the pipeline keeps advancing even under a downstream stall. Empty slots at the head of the stream are therefore consumed rather than frozen in place. A sticky "armed" flag records the first accepted word. From then on the stall passes straight through, so gaps that arrive after the first word stay in the pipeline unchanged.

Top module: `shared_stall_pipe`

## Requirements
- R1: After a synchronous active-low reset, `dst_valid` is 0 and `src_stall` is 0, whatever `dst_stall` is.
- R2: With `dst_stall` low, a word accepted at clock edge t shows up on `dst_valid`/`dst_data` after edge t+DEPTH-1, which is DEPTH edges in total.
- R3: The output word equals the input word passed through stages k = 0..DEPTH-1 in order. Each stage computes y = (x*MUL_K + k + 1) mod 2^WIDTH.
- R4: Once armed, `src_stall` equals `dst_stall` in the same cycle, with no register between them.
- R5: Before the first word is accepted, `src_stall` stays 0 even while `dst_stall` is 1. A word offered in that state is accepted, and it arms the pipeline.
- R6: While armed and `dst_stall` is 1, no stage moves. `dst_valid` and `dst_data` hold their values, and a word held inside the pipeline does not advance.
- R7: A gap between two accepted words after arming is preserved. Words accepted at edges t and t+2 leave DEPTH edges later, with an invalid cycle between them.
- R8: A word is transferred in when `src_valid`=1 and `src_stall`=0, and out when `dst_valid`=1 and `dst_stall`=0. Under any pattern of valid and stall, the output stream equals the input stream in order, with nothing lost or duplicated.
- R9: The armed state is sticky until reset. An empty but armed pipeline still stalls the producer under `dst_stall`, and a word offered while `src_stall` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Input word valid |
| src_data | input | WIDTH | Input word |
| src_stall | output | 1 | Stall toward the producer |
| dst_valid | output | 1 | Output word valid |
| dst_data | output | WIDTH | Output word |
| dst_stall | input | 1 | Stall from the consumer |

## Verification
Embedded properties check on every cycle:
- the producer is stalled only when the consumer is;
- a valid output under stall forces a producer stall;
- a stalled output holds its value;
- the armed flag, once set, never clears.

Directed scenarios show the rest:
- exact latency and the arithmetic result;
- how leading gaps are consumed under stall before arming;
- that mid-stream gaps are kept;
- that words offered during a stall are ignored.

A randomized scenario checks in-order, loss-free, duplicate-free transfer against a reference queue.

// File: rtl/shared_stall_pkg.sv
// Package: shared arithmetic step used by every pipeline stage.
// Assumes operands fit in 64 bits; callers truncate the result.
package shared_stall_pkg;

    // One stage step: x * mul + idx + 1, computed at 64-bit width.
    function automatic logic [63:0] stage_math(
        input logic [63:0] x,
        input logic [31:0] mul,
        input logic [31:0] idx
    );
        return (x * {32'd0, mul}) + {32'd0, idx} + 64'd1;
    endfunction

endpackage

// File: rtl/ssp_stage.sv
// ssp_stage: one register stage of the pipeline (data word plus valid flag).
// Loads on the shared enable; computes (x*MUL_K + IDX + 1) mod 2^WIDTH.
// Assumes WIDTH < 64.
module ssp_stage
    import shared_stall_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned MUL_K = 3,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             vin,
    input  logic [WIDTH-1:0] din,
    output logic             vout,
    output logic [WIDTH-1:0] dout
);
    localparam logic [31:0] MUL_V = MUL_K;
    localparam logic [31:0] IDX_V = IDX;
    localparam int unsigned PAD   = 64 - WIDTH;

    logic [63:0] wide;

    // Stage arithmetic at full width.
    always_comb begin
        wide = stage_math({{PAD{1'b0}}, din}, MUL_V, IDX_V);
    end

    // Stage register: clears on reset, loads only when the shared enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else if (en) begin
            vout <= vin;
            dout <= wide[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/ssp_ctrl.sv
// ssp_ctrl: arming flag and the broadcast enable for the pipeline.
// Before arming, the stages always advance and the producer is never stalled.
// After arming, the consumer stall freezes all stages and passes to the producer.
module ssp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic src_valid,
    input  logic dst_stall,
    output logic en,
    output logic src_stall,
    output logic armed
);
    logic armed_q;

    // Broadcast enable and upstream stall, combinational from the consumer stall.
    always_comb begin
        en        = !armed_q || !dst_stall;
        src_stall = armed_q && dst_stall;
        armed     = armed_q;
    end

    // Arming flag: set by the first accepted word, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (src_valid && en) begin
            armed_q <= 1'b1;
        end
    end

    // R9: once armed, the flag stays set.
    p_armed_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);

    // R5: any accepted word leaves the pipeline armed.
    p_accept_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_stall) |=> armed_q);

endmodule

// File: rtl/shared_stall_pipe.sv
// shared_stall_pipe: DEPTH fixed-latency multiply-add stages under one
// shared stall enable. Leading gaps are consumed before the first word;
// afterwards every stage freezes together under the consumer stall.
// Assumes 1 <= DEPTH and WIDTH < 64; no output buffering.
module shared_stall_pipe
    import shared_stall_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned MUL_K = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid,
    input  logic [WIDTH-1:0] src_data,
    output logic             src_stall,
    output logic             dst_valid,
    output logic [WIDTH-1:0] dst_data,
    input  logic             dst_stall
);
    localparam int unsigned TAPS = DEPTH + 1;

    logic             en;
    logic             armed;
    logic             v_chain [TAPS];
    logic [WIDTH-1:0] d_chain [TAPS];

    // Chain head: producer word enters tap 0.
    always_comb begin
        v_chain[0] = src_valid;
        d_chain[0] = src_data;
    end

    ssp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .dst_stall (dst_stall),
        .en        (en),
        .src_stall (src_stall),
        .armed     (armed)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        ssp_stage #(
            .WIDTH (WIDTH),
            .MUL_K (MUL_K),
            .IDX   (k)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .vin   (v_chain[k]),
            .din   (d_chain[k]),
            .vout  (v_chain[k+1]),
            .dout  (d_chain[k+1])
        );
    end

    // Chain tail drives the consumer side.
    always_comb begin
        dst_valid = v_chain[DEPTH];
        dst_data  = d_chain[DEPTH];
    end

    // R4: a valid output exists only after arming, so a stall on it reaches the producer.
    p_stall_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_stall && dst_valid) |-> src_stall);

    // R5: the producer is never stalled without a consumer stall.
    p_no_spurious_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_stall |-> dst_stall);

    // R6: a stalled output word is held unchanged.
    p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_stall) |=> (dst_valid && $stable(dst_data)));

    // R6: armed and stalled means the output register does not move.
    p_freeze_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dst_stall) |=> ($stable(dst_valid) && $stable(dst_data)));

endmodule

// File: tb/test_shared_stall_pipe.sv
module test_shared_stall_pipe;
    localparam int DEPTH = 4;
    localparam int WIDTH = 16;
    localparam int MUL_K = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_valid = 1'b0;
    logic [WIDTH-1:0] src_data = '0;
    logic             src_stall;
    logic             dst_valid;
    logic [WIDTH-1:0] dst_data;
    logic             dst_stall = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [WIDTH-1:0] model_q [$];

    shared_stall_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MUL_K(MUL_K)) i_shared_stall_pipe (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_stall(src_stall), .dst_valid(dst_valid), .dst_data(dst_data),
        .dst_stall(dst_stall)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Expected result per R3.
    function automatic logic [WIDTH-1:0] expect_word(input logic [WIDTH-1:0] x);
        logic [31:0] v;
        v = {16'd0, x};
        for (int k = 0; k < DEPTH; k++) v = ((v * MUL_K) + k + 1) & 32'h0000_FFFF;
        return v[WIDTH-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_valid = 1'b0; dst_stall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: outputs after reset, with the consumer stall high.
    task automatic t_reset();
        do_reset();
        dst_stall = 1'b1;
        #1;
        check(dst_valid == 1'b0, "R1 dst_valid", dst_valid, 0);
        check(src_stall == 1'b0, "R1 src_stall", src_stall, 0);
        @(negedge clk); dst_stall = 1'b0;
    endtask

    // R2, R3: latency and arithmetic with no stall.
    task automatic t_latency();
        do_reset();
        @(negedge clk); src_valid = 1'b1; src_data = 16'h1234;
        for (int i = 1; i <= DEPTH; i++) begin
            @(negedge clk); src_valid = 1'b0;
            if (i < DEPTH) check(dst_valid == 1'b0, "R2 early valid", dst_valid, 0);
            else begin
                check(dst_valid == 1'b1, "R2 valid at latency", dst_valid, 1);
                check(dst_data == expect_word(16'h1234), "R3 data", dst_data, expect_word(16'h1234));
            end
        end
    endtask

    // R5, R4, R6: leading gaps under stall, then freeze, then release.
    task automatic t_leading();
        logic [WIDTH-1:0] e;
        e = expect_word(16'h00A5);
        do_reset();
        @(negedge clk); dst_stall = 1'b1; #1;
        check(src_stall == 1'b0, "R5 no stall before first word", src_stall, 0);
        repeat (3) @(negedge clk);
        src_valid = 1'b1; src_data = 16'h00A5; #1;
        check(src_stall == 1'b0, "R5 first word accepted", src_stall, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); src_valid = 1'b0; #1;
            check(src_stall == 1'b1, "R4 stall passes once armed", src_stall, 1);
            check(dst_valid == 1'b0, "R6 held word does not advance", dst_valid, 0);
        end
        @(negedge clk); dst_stall = 1'b0; #1;
        check(src_stall == 1'b0, "R4 stall release", src_stall, 0);
        for (int i = 1; i < DEPTH; i++) @(negedge clk);
        check(dst_valid == 1'b1, "R6 word after release", dst_valid, 1);
        check(dst_data == e, "R3 data after release", dst_data, e);
        dst_stall = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(dst_valid == 1'b1 && dst_data == e, "R6 output held", dst_data, e);
        end
        dst_stall = 1'b0;
        @(negedge clk);
        check(dst_valid == 1'b0, "R8 word leaves once", dst_valid, 0);
    endtask

    // R7 then R9: gap kept; armed empty pipe still stalls and ignores input.
    task automatic t_gap_and_sticky();
        do_reset();
        @(negedge clk); src_valid = 1'b1; src_data = 16'h0011;
        for (int i = 1; i <= DEPTH + 2; i++) begin
            @(negedge clk);
            src_valid = (i == 2); src_data = 16'h0022;
            if (i == DEPTH)     check(dst_valid && dst_data == expect_word(16'h0011), "R7 first word", dst_data, expect_word(16'h0011));
            if (i == DEPTH + 1) check(dst_valid == 1'b0, "R7 gap kept", dst_valid, 0);
            if (i == DEPTH + 2) check(dst_valid && dst_data == expect_word(16'h0022), "R7 second word", dst_data, expect_word(16'h0022));
        end
        src_valid = 1'b0;
        repeat (2) @(negedge clk);
        dst_stall = 1'b1; src_valid = 1'b1; src_data = 16'h0077; #1;
        check(src_stall == 1'b1, "R9 armed empty pipe stalls", src_stall, 1);
        repeat (3) @(negedge clk);
        src_valid = 1'b0; dst_stall = 1'b0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            @(negedge clk);
            check(dst_valid == 1'b0, "R9 stalled offer ignored", dst_valid, 0);
        end
    endtask

    // R8: random valid/stall traffic against a reference queue.
    task automatic t_random();
        int seed = 7;
        logic [WIDTH-1:0] exp_w;
        do_reset();
        model_q.delete();
        for (int c = 0; c < 3000 + DEPTH + 4; c++) begin
            @(negedge clk);
            if (c < 3000) begin
                src_valid = (($random(seed) & 7) < 5);
                src_data  = $random(seed);
                dst_stall = (($random(seed) & 3) == 0);
            end else begin
                src_valid = 1'b0; dst_stall = 1'b0;
            end
            #1;
            if (src_valid && !src_stall) model_q.push_back(expect_word(src_data));
            if (dst_valid && !dst_stall) begin
                if (model_q.size() == 0) check(1'b0, "R8 duplicate output", dst_data, 0);
                else begin
                    exp_w = model_q.pop_front();
                    check(dst_data == exp_w, "R8 stream order", dst_data, exp_w);
                end
            end
        end
        check(model_q.size() == 0, "R8 no lost words", model_q.size(), 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_leading();
        t_gap_and_sticky();
        t_random();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule